// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank with Read Snapshot

This block holds four independent 32-bit down-counters behind a small register bus. Each counter is armed from its own reload register and counts while both a bank-wide run bit and its own run bit are set. When a counter passes through zero it re-arms from the reload register, bumps a 32-bit wrap tally and raises a sticky event flag. Each flag can reach an interrupt line only through a per-channel mask bit.

Software never reads a live count directly. A read of a channel's wrap-tally register returns the tally and, in the same clock, freezes the live count into that channel's count register. A later read of the count register therefore returns a value that belongs with the tally just read, so the tally must always be read first. When a channel is armed with all ones it runs freely, and the bitwise inverse of the captured count serves as a rising time base.

Bus reads are registered: the read data appears on the clock after the read strobe and holds until the next read.

Top module: `gpt_bank`

## Requirements
- R1: After reset every channel register, the bank run bit, `rd_data` and all `irq` lines are zero.
- R2: Register map. Bank window (address bits [7:5] = 0): run control at 0x00 (bit 0) and a read-only revision word at 0x10 that returns the REVISION parameter. Channel c uses the window at 0x20*(c+1), with these offsets: 0x00 arm bit (bit 0), 0x04 reload, 0x08 captured count, 0x0C wrap tally, 0x10 event flag (bit 0), 0x14 flag clear, 0x18 interrupt mask (bit 0). Read data appears on `rd_data` one clock after `rd_en` and holds until the next read.
- R3: A counter decreases by one on every clock while both the bank run bit and its arm bit are 1. Otherwise it holds its value.
- R4: A write of 1 to the arm bit while that bit is 0 copies the reload register into the counter on that clock. Counting starts on the following clock.
- R5: When a running counter is at 0, on the next clock it takes the reload value, its wrap tally increases by one (modulo 2^32) and its event flag is set.
- R6: A read of the wrap tally copies the counter value from before that clock edge into the captured-count register. A read of the captured count returns the last copy and never the live value.
- R7: A write with bit 0 set to the flag-clear offset clears the event flag. If a wrap happens on the same clock, the flag stays set. A write with bit 0 clear has no effect.
- R8: `irq[c]` is 1 exactly when channel c's event flag and mask bit are both 1.
- R9: Reads of unmapped offsets and of the flag-clear offset return zero. Writes to the revision, captured-count, wrap-tally and event-flag offsets change nothing.
- R10: With a reload of 0xFFFFFFFF, the inverse of two captures taken N clocks apart differs by exactly N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Registered read data |
| irq | output | NUM_CH | Per-channel masked interrupt lines |

## Verification
The bench targets four corner cases.
- Ordering between capture and count: a design that latched the value after the decrement, or that refreshed the captured count continuously, would return counts one cycle off, or counts that do not match the tally just read.
- A flag clear that lands in the same cycle as a wrap: a design that gave the clear priority would lose an event.
- Re-arming a channel that is already armed: a design that reloaded on every write of 1, rather than only on the 0-to-1 change, would restart the count.
- Writes to read-only offsets and reads of holes in the map: a design that decoded too loosely would corrupt state or return stray data.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  // width of the in-window byte offset; each window spans 32 bytes
  localparam int OFF_W = 5;

  typedef enum logic [2:0] {
    CR_NONE, CR_ARM, CR_RELOAD, CR_CAPT, CR_TALLY, CR_FLAG, CR_CLR, CR_MASK
  } chan_reg_e;

  typedef enum logic [1:0] {TR_NONE, TR_RUN, TR_REV} top_reg_e;

  function automatic chan_reg_e chan_reg_of(input logic [OFF_W-1:0] off);
    case (off)
      5'h00:   return CR_ARM;
      5'h04:   return CR_RELOAD;
      5'h08:   return CR_CAPT;
      5'h0C:   return CR_TALLY;
      5'h10:   return CR_FLAG;
      5'h14:   return CR_CLR;
      5'h18:   return CR_MASK;
      default: return CR_NONE;
    endcase
  endfunction

  function automatic top_reg_e top_reg_of(input logic [OFF_W-1:0] off);
    case (off)
      5'h00:   return TR_RUN;
      5'h10:   return TR_REV;
      default: return TR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpt_decode.sv
module gpt_decode
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output top_reg_e          top_sel,
  output logic [NUM_CH-1:0] ch_hit,
  output chan_reg_e         ch_sel
);
  localparam int WIN_W = ADDR_W - OFF_W;

  logic [WIN_W-1:0] win;
  logic [OFF_W-1:0] off;

  assign win     = addr[ADDR_W-1:OFF_W];
  assign off     = addr[OFF_W-1:0];
  assign ch_sel  = chan_reg_of(off);
  assign top_sel = (win == '0) ? top_reg_of(off) : TR_NONE;

  // window 0 is the bank window; channel c sits in window c+1
  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_hit[i] = (win == WIN_W'(i + 1)) && (ch_sel != CR_NONE);
  end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_run,
  input  logic             hit,
  input  chan_reg_e        sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rd_val,
  output logic             irq,
  output logic             wrap_o,
  output logic             run_o,
  output logic             load_o,
  output logic             flag_o,
  output logic             mask_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             arm_q, mask_q, flag_q;
  logic [CNT_W-1:0] cnt_q, rel_q, tally_q, capt_q;

  logic wr_arm, wr_rel, wr_clr, wr_mask, rd_tally;
  logic run, load, wrap;

  function automatic logic [CNT_W-1:0] count_next(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rel,
    input logic             go,
    input logic             ld
  );
    if (ld)         return rel;
    if (!go)        return cur;
    if (cur == '0)  return rel;
    return cur - CNT_W'(1);
  endfunction

  assign wr_arm   = wr & hit & (sel == CR_ARM);
  assign wr_rel   = wr & hit & (sel == CR_RELOAD);
  assign wr_clr   = wr & hit & (sel == CR_CLR);
  assign wr_mask  = wr & hit & (sel == CR_MASK);
  assign rd_tally = rd & hit & (sel == CR_TALLY);

  assign run  = bank_run & arm_q;
  assign load = wr_arm & wdata[0] & ~arm_q;
  assign wrap = run & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      mask_q  <= 1'b0;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
      rel_q   <= '0;
      tally_q <= '0;
      capt_q  <= '0;
    end else begin
      cnt_q <= count_next(cnt_q, rel_q, run, load);
      if (wrap)                 tally_q <= tally_q + CNT_W'(1);
      if (wrap)                 flag_q  <= 1'b1;
      else if (wr_clr & wdata[0]) flag_q <= 1'b0;
      if (wr_arm)               arm_q   <= wdata[0];
      if (wr_rel)               rel_q   <= wdata;
      if (wr_mask)              mask_q  <= wdata[0];
      if (rd_tally)             capt_q  <= cnt_q;
    end
  end

  always_comb begin
    case (sel)
      CR_ARM:    rd_val = CNT_W'(arm_q);
      CR_RELOAD: rd_val = rel_q;
      CR_CAPT:   rd_val = capt_q;
      CR_TALLY:  rd_val = tally_q;
      CR_FLAG:   rd_val = CNT_W'(flag_q);
      CR_MASK:   rd_val = CNT_W'(mask_q);
      default:   rd_val = '0;
    endcase
  end

  assign irq    = flag_q & mask_q;
  assign wrap_o = wrap;
  assign run_o  = run;
  assign load_o = load;
  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/gpt_bank.sv
module gpt_bank
  import gpt_pkg::*;
#(
  parameter int               NUM_CH   = 4,
  parameter int               CNT_W    = 32,
  parameter int               ADDR_W   = 8,
  parameter logic [CNT_W-1:0] REVISION = 32'h0001_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] irq
);
  top_reg_e          top_sel;
  chan_reg_e         ch_sel;
  logic [NUM_CH-1:0] ch_hit;
  logic              run_q;
  logic [CNT_W-1:0]  rd_next;
  logic [CNT_W-1:0]  ch_rd [NUM_CH];

  // named per-channel events for the checker
  logic [NUM_CH-1:0]       ch_wrap, ch_run, ch_load, ch_flag, ch_mask;
  logic [NUM_CH*CNT_W-1:0] ch_cnt;

  gpt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .top_sel (top_sel),
    .ch_hit  (ch_hit),
    .ch_sel  (ch_sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    gpt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .bank_run (run_q),
      .hit      (ch_hit[i]),
      .sel      (ch_sel),
      .wr       (wr_en),
      .rd       (rd_en),
      .wdata    (wr_data),
      .rd_val   (ch_rd[i]),
      .irq      (irq[i]),
      .wrap_o   (ch_wrap[i]),
      .run_o    (ch_run[i]),
      .load_o   (ch_load[i]),
      .flag_o   (ch_flag[i]),
      .mask_o   (ch_mask[i]),
      .cnt_o    (ch_cnt[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_next = '0;
    case (top_sel)
      TR_RUN:  rd_next = CNT_W'(run_q);
      TR_REV:  rd_next = REVISION;
      default: rd_next = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++)
      if (ch_hit[i]) rd_next = rd_next | ch_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && top_sel == TR_RUN) run_q <= wr_data[0];
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
  parameter int               NUM_CH   = 4,
  parameter int               CNT_W    = 32,
  parameter int               ADDR_W   = 8,
  parameter logic [CNT_W-1:0] REVISION = '0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [CNT_W-1:0]        rd_data,
  input logic [NUM_CH-1:0]       irq,
  input logic [NUM_CH-1:0]       ch_wrap,
  input logic [NUM_CH-1:0]       ch_run,
  input logic [NUM_CH-1:0]       ch_load,
  input logic [NUM_CH-1:0]       ch_flag,
  input logic [NUM_CH-1:0]       ch_mask,
  input logic [NUM_CH*CNT_W-1:0] ch_cnt
);
  localparam logic [ADDR_W-1:0] REV_ADDR = ADDR_W'(16);

  // R2
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == REV_ADDR |=> rd_data == REVISION);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[i] && !ch_load[i] |=> $stable(ch_cnt[i*CNT_W +: CNT_W]));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[i] && ch_cnt[i*CNT_W +: CNT_W] != '0
      |=> ch_cnt[i*CNT_W +: CNT_W] == $past(ch_cnt[i*CNT_W +: CNT_W]) - CNT_W'(1));
    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wrap[i] |=> ch_flag[i]);
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_mask[i] |-> !irq[i]);
    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ch_flag[i]);
  end
endmodule

bind gpt_bank gpt_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REVISION(REVISION)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .addr    (addr),
  .rd_data (rd_data),
  .irq     (irq),
  .ch_wrap (ch_wrap),
  .ch_run  (ch_run),
  .ch_load (ch_load),
  .ch_flag (ch_flag),
  .ch_mask (ch_mask),
  .ch_cnt  (ch_cnt)
);

// File: tb/gpt_bank_test.sv
module gpt_bank_test;
  localparam int          CLK_NS = 10;
  localparam int          NCH    = 4;
  localparam logic [31:0] REV    = 32'h0001_0002;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]     addr  = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] irq;

  always #(CLK_NS/2) clk = ~clk;

  gpt_bank #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(8), .REVISION(REV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .rd_en(rd), .addr(addr),
    .wr_data(wdata), .rd_data(rdata), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, irq_on = 0;

  // reference state built from the requirements
  logic        m_run;
  logic        m_arm [NCH], m_flag [NCH], m_mask [NCH];
  logic [31:0] m_rel [NCH], m_cnt [NCH], m_tally [NCH], m_capt [NCH];
  logic [31:0] m_rdata;
  string       m_tag;

  function automatic logic [7:0] ch_addr(int c, int off);
    return 8'(32 * (c + 1) + off);
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    int w = int'(a[7:5]);
    int o = int'(a[4:0]);
    if (w == 0) return (o == 0) ? {31'b0, m_run} : (o == 16) ? REV : 32'h0;
    if (w > NCH) return 32'h0;
    case (o)
      0:  return {31'b0, m_arm[w-1]};
      4:  return m_rel[w-1];
      8:  return m_capt[w-1];
      12: return m_tally[w-1];
      16: return {31'b0, m_flag[w-1]};
      24: return {31'b0, m_mask[w-1]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    int w = int'(a[7:5]);
    int o = int'(a[4:0]);
    if (w == 0) return (o == 0 || o == 16) ? "R2" : "R9";
    if (w > NCH) return "R9";
    case (o)
      8, 12:   return "R6";
      16:      return "R5";
      24:      return "R8";
      0, 4:    return "R4";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    logic hit, go, wrp, ld;
    int o;
    if (!rst_n) begin
      m_run = 0; m_rdata = 0; m_tag = "R1";
      for (int c = 0; c < NCH; c++) begin
        m_arm[c] = 0; m_flag[c] = 0; m_mask[c] = 0;
        m_rel[c] = 0; m_cnt[c] = 0; m_tally[c] = 0; m_capt[c] = 0;
      end
    end else begin
      if (rd) begin m_rdata = model_read(addr); m_tag = tag_of(addr); end
      o = int'(addr[4:0]);
      for (int c = 0; c < NCH; c++) begin
        hit = (int'(addr[7:5]) == c + 1);
        go  = m_run && m_arm[c];
        wrp = go && m_cnt[c] == 0;
        ld  = wr && hit && o == 0 && wdata[0] && !m_arm[c];
        if (rd && hit && o == 12) m_capt[c] = m_cnt[c];
        if (ld || wrp) m_cnt[c] = m_rel[c];
        else if (go)   m_cnt[c] = m_cnt[c] - 1;
        if (wrp) begin m_tally[c] = m_tally[c] + 1; m_flag[c] = 1; end
        else if (wr && hit && o == 20 && wdata[0]) m_flag[c] = 0;
        if (wr && hit && o == 0)  m_arm[c]  = wdata[0];
        if (wr && hit && o == 4)  m_rel[c]  = wdata;
        if (wr && hit && o == 24) m_mask[c] = wdata[0];
      end
      if (wr && addr == 8'h00) m_run = wdata[0];
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // R8: interrupt lines against the reference on every cycle
  always @(negedge clk) if (irq_on) begin
    logic [NCH-1:0] e;
    for (int c = 0; c < NCH; c++) e[c] = m_flag[c] & m_mask[c];
    check("R8", 32'(irq), 32'(e));
  end

  // tasks start and end at a falling edge
  task automatic do_write(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_read(logic [7:0] a);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    check(m_tag, rdata, m_rdata);
  endtask

  task automatic read_exp(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    check(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [31:0] s1, s2;
    void'($urandom(32'h5eed_0042));
    idle(2);
    // R1: state while reset is held
    check("R1", rdata, 32'h0);
    check("R1", 32'(irq), 32'h0);
    rst_n = 1;
    irq_on = 1;
    // R1: every channel register reads zero
    for (int c = 0; c < NCH; c++)
      foreach (s1[k]) if (k < 7) read_exp(ch_addr(c, 4 * k), 32'h0, "R1");
    read_exp(8'h00, 32'h0, "R1");
    // R2: revision word; R9: writes to it are ignored
    read_exp(8'h10, REV, "R2");
    do_write(8'h10, 32'hFFFF_FFFF);
    read_exp(8'h10, REV, "R9");
    // R9: holes in the map
    read_exp(8'h04, 32'h0, "R9");
    read_exp(ch_addr(0, 28), 32'h0, "R9");
    read_exp(8'hA0, 32'h0, "R9");
    read_exp(8'hFF, 32'h0, "R9");

    // R4: arming loads the reload value; R3: holds while bank run is 0
    do_write(ch_addr(1, 4), 32'd100);
    do_write(ch_addr(1, 0), 32'd1);
    idle(5);
    read_exp(ch_addr(1, 12), 32'h0, "R6");
    read_exp(ch_addr(1, 8), 32'd100, "R4");
    // R9: write to captured count is ignored
    do_write(ch_addr(1, 8), 32'h1234);
    read_exp(ch_addr(1, 8), 32'd100, "R9");

    // R10: free-running channel 0
    do_write(ch_addr(0, 4), 32'hFFFF_FFFF);
    do_write(ch_addr(0, 0), 32'd1);
    do_write(8'h00, 32'd1);
    idle(3);
    read_exp(ch_addr(0, 12), 32'h0, "R6");
    do_read(ch_addr(0, 8)); s1 = rdata;
    idle(17);
    do_read(ch_addr(0, 12));
    do_read(ch_addr(0, 8)); s2 = rdata;
    check("R10", (~s2) - (~s1), 32'd19);

    // R4: re-arming an armed channel does not reload
    idle(4);
    do_write(ch_addr(1, 0), 32'd1);
    do_read(ch_addr(1, 12));
    do_read(ch_addr(1, 8));

    // R5: short period wraps on channel 2
    do_write(ch_addr(2, 4), 32'd3);
    do_write(ch_addr(2, 0), 32'd1);
    idle(20);
    read_exp(ch_addr(2, 16), 32'd1, "R5");
    do_read(ch_addr(2, 12));
    // R8: mask gates the line
    do_write(ch_addr(2, 24), 32'd1);
    idle(2);
    check("R8", 32'(irq[2]), 32'd1);
    // R7: clear in the wrap cycle leaves the flag set
    while (!(m_cnt[2] == 0)) @(negedge clk);
    do_write(ch_addr(2, 20), 32'd1);
    read_exp(ch_addr(2, 16), 32'd1, "R7");
    // R7: clear with bit 0 low does nothing, then a real clear
    do_write(ch_addr(2, 0), 32'd0);
    do_write(ch_addr(2, 20), 32'd2);
    read_exp(ch_addr(2, 16), 32'd1, "R7");
    do_write(ch_addr(2, 20), 32'd1);
    read_exp(ch_addr(2, 16), 32'd0, "R7");
    check("R8", 32'(irq[2]), 32'd0);

    // mixed random traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      int c = int'($urandom % NCH);
      int o = 4 * int'($urandom % 8);
      logic [7:0] a = ($urandom % 10 == 0) ? 8'(o & 16) : ch_addr(c, o);
      logic [31:0] d = (o == 4) ? (($urandom % 8 == 0) ? $urandom : $urandom % 20)
                                : $urandom;
      if (r < 35)      do_write(a, d);
      else if (r < 75) do_read(a);
      else             idle(1);
    end
    idle(2);
    finish_up();
  end
endmodule